// File: doc/BRIEF.md
# Breakpoint Trap and Runtime Counter

This block sits beside a small CPU's instruction decoder. On each decode strobe it looks at the opcode byte. The breakpoint opcode is 0x00, which is also the value of a fully programmed flash byte.

- If breakpoints are enabled, a decoded 0x00 stops the CPU at once and puts the block into debug mode.
- If breakpoints are disabled, the block flags the instruction so that it runs as a no-operation.

A host leaves debug mode with a one-cycle "go" pulse.

A 16-bit runtime counter measures each run interval in system clock cycles. It clears to zero when debug mode is left. It advances on every clock edge taken while the CPU runs, including the edge that samples the trapping breakpoint. It freezes while the block is in debug mode. It holds at its all-ones value once it gets there. After a breakpoint, the host reads the count to learn how many cycles the program ran.

Top module: `bkpt_trap_unit`

## Requirements
- R1: While reset is applied and just after it is released, `dbg_mode_o` = 1, `cpu_idle_o` = 1, `nop_sub_o` = 0 and `run_count_o` = 0.
- R2: A decode strobe with opcode 0x00 while `bp_enable_i` = 1 raises `cpu_idle_o` in that same cycle, and `dbg_mode_o` reads 1 after the next clock edge.
- R3: A decode strobe with opcode 0x00 while `bp_enable_i` = 0 raises `nop_sub_o` in that cycle, keeps `cpu_idle_o` at 0 while running, and leaves the mode and the count sequence unchanged.
- R4: A decode strobe with any opcode other than 0x00 has no effect on mode, idle, no-op flag or count, whatever the enable bit is.
- R5: While the decode strobe is low, the opcode bus has no effect.
- R6: A `host_go_i` pulse in debug mode, without a breakpoint in the same cycle, clears `dbg_mode_o` at the next clock edge and drops `cpu_idle_o`.
- R7: A breakpoint and a go pulse in the same cycle leave the block in debug mode.
- R8: Outside debug mode the count rises by one on every clock edge, including the edge that enters debug mode. Inside debug mode it stays constant.
- R9: The count stops at 0xFFFF and holds there until the next exit from debug mode.
- R10: The count reads 0 right after the edge that leaves debug mode.
- R11: A go pulse while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dec_valid_i | input | 1 | Instruction decode strobe |
| dec_opcode_i | input | 8 | Opcode byte being decoded |
| bp_enable_i | input | 1 | Breakpoints enabled |
| host_go_i | input | 1 | Host request to leave debug mode (one-cycle pulse) |
| dbg_mode_o | output | 1 | Debug mode flag |
| cpu_idle_o | output | 1 | Request to idle the CPU |
| nop_sub_o | output | 1 | Execute the current opcode as a no-operation |
| run_count_o | output | 16 | Runtime counter value |

## Verification
A wrong mode bit shows on `dbg_mode_o` and `cpu_idle_o` one edge after the stimulus. A wrong counter state appears on `run_count_o` no later than the next run edge, as an off-by-one, a count that moves while frozen, or a wrap to zero past 0xFFFF. The bench keeps its own cycle-level model of mode and count and compares it with the ports after every edge. It sweeps all 255 non-breakpoint opcodes, both enable settings, same-cycle go and breakpoint, several interval lengths, and one full run to saturation.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    // Mode controller state
    typedef struct packed {
        logic dbg;
    } mode_st_t;

endpackage

// File: rtl/bkpt_decode.sv
module bkpt_decode #(
    parameter int              OP_W       = 8,
    parameter logic [OP_W-1:0] BRK_OPCODE = '0
) (
    input  logic            valid_i,
    input  logic [OP_W-1:0] opcode_i,
    input  logic            enable_i,
    output logic            trap_o,
    output logic            nop_o
);

    logic is_brk;

    always_comb begin
        is_brk = valid_i && (opcode_i == BRK_OPCODE);
        trap_o = is_brk && enable_i;
        nop_o  = is_brk && !enable_i;
    end

endmodule

// File: rtl/bkpt_mode_ctl.sv
module bkpt_mode_ctl
    import bkpt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trap_i,
    input  logic go_i,
    output logic dbg_o,
    output logic leave_o,
    output logic idle_o
);

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trap_i) begin
            st_d.dbg = 1'b1;          // breakpoint wins over go
        end else if (go_i) begin
            st_d.dbg = 1'b0;
        end
        leave_o = st_q.dbg && !st_d.dbg;
        idle_o  = st_q.dbg || trap_i;
        dbg_o   = st_q.dbg;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.dbg <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    p_trap_enters_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> dbg_o);
    p_go_exits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_o && go_i && !trap_i) |=> !dbg_o);
    p_brk_beats_go_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_o && go_i && trap_i) |=> dbg_o);
    p_run_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dbg_o && !trap_i) |=> !dbg_o);

endmodule

// File: rtl/bkpt_runtime_ctr.sv
module bkpt_runtime_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dbg_i,
    input  logic             leave_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (leave_i) begin
            cnt_d = '0;
        end else if (!dbg_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
        cnt_o = cnt_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    p_step_when_running_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dbg_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
    p_frozen_in_debug_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_i && !leave_i) |=> $stable(cnt_q));
    p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CNT_MAX && !leave_i) |=> cnt_q == CNT_MAX);
    p_clear_on_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        leave_i |=> cnt_q == '0);

endmodule

// File: rtl/bkpt_trap_unit.sv
module bkpt_trap_unit #(
    parameter int              CNT_W      = 16,
    parameter int              OP_W       = 8,
    parameter logic [OP_W-1:0] BRK_OPCODE = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dec_valid_i,
    input  logic [OP_W-1:0]  dec_opcode_i,
    input  logic             bp_enable_i,
    input  logic             host_go_i,
    output logic             dbg_mode_o,
    output logic             cpu_idle_o,
    output logic             nop_sub_o,
    output logic [CNT_W-1:0] run_count_o
);

    logic trap, leave;

    bkpt_decode #(
        .OP_W       (OP_W),
        .BRK_OPCODE (BRK_OPCODE)
    ) u_decode (
        .valid_i  (dec_valid_i),
        .opcode_i (dec_opcode_i),
        .enable_i (bp_enable_i),
        .trap_o   (trap),
        .nop_o    (nop_sub_o)
    );

    bkpt_mode_ctl u_mode (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trap_i  (trap),
        .go_i    (host_go_i),
        .dbg_o   (dbg_mode_o),
        .leave_o (leave),
        .idle_o  (cpu_idle_o)
    );

    bkpt_runtime_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .dbg_i   (dbg_mode_o),
        .leave_i (leave),
        .cnt_o   (run_count_o)
    );

    p_disabled_brk_no_halt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nop_sub_o && !dbg_mode_o && !host_go_i) |=> !dbg_mode_o);
    p_other_opcode_no_halt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dbg_mode_o && dec_valid_i && dec_opcode_i != BRK_OPCODE) |=> !dbg_mode_o);
    p_idle_in_debug_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_mode_o |-> cpu_idle_o);

endmodule

// File: tb/bkpt_trap_unit_bench.sv
module bkpt_trap_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid;
    logic [7:0]  opcode;
    logic        en;
    logic        go;
    logic        dbg, idle, nop;
    logic [15:0] cnt;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic        m_dbg;
    logic [15:0] m_cnt;

    always #5 clk = ~clk;

    bkpt_trap_unit u_bkpt_trap_unit (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .dec_valid_i  (valid),
        .dec_opcode_i (opcode),
        .bp_enable_i  (en),
        .host_go_i    (go),
        .dbg_mode_o   (dbg),
        .cpu_idle_o   (idle),
        .nop_sub_o    (nop),
        .run_count_o  (cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one clock edge, update the model, compare mode and count.
    task automatic tick();
        logic brk;
        brk = valid && (opcode == 8'h00) && en;
        if (m_dbg && go && !brk) begin
            m_cnt = 16'h0;                      // R10
        end else if (!m_dbg && m_cnt != 16'hFFFF) begin
            m_cnt = m_cnt + 16'h1;              // R8, R9
        end
        if (brk)     m_dbg = 1'b1;              // R2, R7
        else if (go) m_dbg = 1'b0;              // R6
        @(posedge clk);
        #2;
        check("R6 mode", dbg, m_dbg);
        check("R8 count", cnt, m_cnt);
    endtask

    task automatic idle_inputs();
        valid = 1'b0; opcode = 8'h00; go = 1'b0;
    endtask

    task automatic exit_debug();
        go = 1'b1;
        tick();
        go = 1'b0;
        check("R10 cleared", cnt, 16'h0);
        check("R6 idle low", idle, 1'b0);
    endtask

    task automatic hit_brk();
        valid = 1'b1; opcode = 8'h00; en = 1'b1;
        #1;
        check("R2 idle same cycle", idle, 1'b1);
        check("R2 no nop", nop, 1'b0);
        tick();
        idle_inputs();
        check("R2 in debug", dbg, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b1; idle_inputs();
        m_dbg = 1'b1; m_cnt = 16'h0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 dbg", dbg, 1'b1);
        check("R1 idle", idle, 1'b1);
        check("R1 nop", nop, 1'b0);
        check("R1 count", cnt, 16'h0);
        rst_n = 1'b1;
        tick();
        check("R1 after release", cnt, 16'h0);

        // R5: opcode bus toggles with no strobe, in both modes
        for (int i = 0; i < 8; i++) begin
            opcode = 8'h00; valid = 1'b0;
            tick();
        end
        exit_debug();
        for (int i = 0; i < 37; i++) begin
            opcode = 8'(i * 7);
            #1;
            check("R5 no nop", nop, 1'b0);
            tick();
        end
        check("R5 count", cnt, 16'd37);

        // R4: every other opcode, both enable settings
        for (int e = 0; e < 2; e++) begin
            en = e[0];
            for (int op = 1; op < 256; op++) begin
                valid = 1'b1; opcode = 8'(op);
                #1;
                check("R4 nop", nop, 1'b0);
                check("R4 idle", idle, 1'b0);
                tick();
            end
        end
        idle_inputs();

        // R3: disabled breakpoint acts as a no-op
        en = 1'b0; valid = 1'b1; opcode = 8'h00;
        #1;
        check("R3 nop", nop, 1'b1);
        check("R3 idle", idle, 1'b0);
        tick();
        check("R3 still running", dbg, 1'b0);
        idle_inputs();
        tick();

        // R11: go while running
        go = 1'b1;
        tick();
        go = 1'b0;
        check("R11 still running", dbg, 1'b0);

        // R2, R8: trap then frozen count
        hit_brk();
        for (int i = 0; i < 20; i++) tick();
        check("R8 frozen", cnt, m_cnt);

        // R7: breakpoint and go together
        go = 1'b1; valid = 1'b1; opcode = 8'h00; en = 1'b1;
        tick();
        idle_inputs();
        check("R7 stays debug", dbg, 1'b1);

        // Intervals of several lengths
        for (int k = 0; k < 5; k++) begin
            int len;
            len = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 5 : 100;
            exit_debug();
            for (int i = 0; i < len; i++) tick();
            hit_brk();
            check("R8 interval", cnt, 16'(len + 1));
            for (int i = 0; i < 3; i++) tick();
        end

        // R9: saturation
        exit_debug();
        for (int i = 0; i < 65534; i++) tick();
        check("R9 one below max", cnt, 16'hFFFE);
        tick();
        check("R9 reached max", cnt, 16'hFFFF);
        for (int i = 0; i < 10; i++) tick();
        check("R9 holds", cnt, 16'hFFFF);
        hit_brk();
        check("R9 holds in debug", cnt, 16'hFFFF);
        exit_debug();
        check("R10 restart", cnt, 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_900_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule